// File: doc/BRIEF.md
# Big-Endian Word Load/Store Stage

This block is the address and data-formatting stage that sits between a core's register read and a byte-addressed data memory. On each request it adds a sign-extended 16-bit displacement to a 32-bit base value, and the sum wraps modulo 2^32. It checks that the resulting byte address is a multiple of four. If it is, the block drives one word-wide memory access. A store drives the data in big-endian lane order with every byte enable set. A load reads the whole word.

The memory is synchronous. Read data appear on the memory port one cycle after the request, and the load returns to the register writeback path in that cycle, tagged with its destination register number. An address that is not word-aligned raises an error flag in the request cycle. It produces no memory access and no writeback, so the address is never rounded down silently.

Top module: `word_lsu`

## Requirements
- R1: The effective address is `base + sign_extend(offset)`, computed modulo 2^32. On an aligned access it is driven on `mem_addr` in the request cycle. Offsets reach from -32768 to +32767 bytes.
- R2: In a request cycle where bits [1:0] of the effective address are not both zero, `misalign_err` is 1. It is 0 in an aligned request cycle and in any cycle with `req_valid` low.
- R3: A misaligned request drives `mem_en`, `mem_we` and all bits of `mem_be` to 0, and gives no `wb_valid` in the following cycle.
- R4: An aligned store (`req_store`=1) drives `mem_en`=1, `mem_we`=1 and `mem_be`=4'b1111 in the request cycle.
- R5: An aligned load (`req_store`=0) drives `mem_en`=1 and `mem_we`=0. One cycle later it gives `wb_valid`=1 with `wb_dest` equal to the request's `req_dest`.
- R6: Big-endian lanes. Bits [31:24] of `mem_wdata`, `mem_rdata`, `store_data` and `wb_data` are the byte at the effective address, and bits [7:0] are the byte at the effective address + 3. A stored word read back by a load returns unchanged.
- R7: While `rst` is high and right after it, `wb_valid` is 0 and `wb_data` is 0.
- R8: With `req_valid` low, `mem_en`, `mem_we` and `mem_be` are 0 and no writeback follows.
- R9: A store never produces `wb_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Word to store, most significant byte first |
| req_dest | input | 5 | Destination register number for a load |
| mem_addr | output | 32 | Byte address of the word access |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Write data in big-endian lane order |
| mem_rdata | input | 32 | Read data, valid one cycle after a load request |
| misalign_err | output | 1 | Effective address not word-aligned |
| wb_valid | output | 1 | Load result valid |
| wb_dest | output | 5 | Destination register of the load result |
| wb_data | output | 32 | Loaded word |

## Verification
A wrong sign extension or a missing carry shows on `mem_addr` in the request cycle itself. It is visible only when the offset is negative or the base sits near the top of the address space, so the stimulus includes both. A swapped lane does not show on a simple store and load round trip, because the swap cancels out. It shows one cycle after a load, in `wb_data`, when the bytes were placed individually in memory, and it shows in the memory's byte contents after a store. A stale writeback-valid state shows as a spurious `wb_valid` in the cycle after a store, a misaligned request or an idle cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int LSU_ADDR_W = 32;
    localparam int LSU_DATA_W = 32;
    localparam int LSU_OFF_W  = 16;
    localparam int LSU_TAG_W  = 5;

    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_t;

    typedef struct packed {
        logic en;
        logic we;
        logic err;
        logic load_go;
    } port_ctl_t;

    function automatic port_ctl_t decide_ctl(input logic valid,
                                             input acc_kind_t kind,
                                             input logic misaligned);
        port_ctl_t c;
        c.err     = valid && misaligned;
        c.en      = valid && !misaligned;
        c.we      = c.en && (kind == ACC_STORE);
        c.load_go = c.en && (kind == ACC_LOAD);
        return c;
    endfunction

endpackage

// File: rtl/lsu_agu.sv
module lsu_agu #(
    parameter int AW    = lsu_pkg::LSU_ADDR_W,
    parameter int OW    = lsu_pkg::LSU_OFF_W,
    parameter int LANES = lsu_pkg::LSU_DATA_W / 8
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] ea,
    output logic          misaligned
);
    localparam int LOW_BITS = $clog2(LANES);

    logic [AW-1:0] off_ext;

    always_comb begin
        off_ext    = {{(AW-OW){offset[OW-1]}}, offset};
        ea         = base + off_ext;
        misaligned = |ea[LOW_BITS-1:0];
    end
endmodule

// File: rtl/lsu_port.sv
module lsu_port
    import lsu_pkg::*;
#(
    parameter int AW = LSU_ADDR_W,
    parameter int DW = LSU_DATA_W
) (
    input  logic          req_valid,
    input  acc_kind_t     kind,
    input  logic [AW-1:0] ea,
    input  logic          misaligned,
    input  logic [DW-1:0] store_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    output logic          misalign_err,
    output logic          load_go
);
    localparam int LANES = DW / 8;

    port_ctl_t ctl;

    always_comb begin
        ctl          = decide_ctl(req_valid, kind, misaligned);
        mem_en       = ctl.en;
        mem_we       = ctl.we;
        misalign_err = ctl.err;
        load_go      = ctl.load_go;
        mem_addr     = ea;
    end

    // Byte k of the word (k = 0 at the lowest address) rides on lane LANES-1-k.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign mem_be[LANES-1-k]             = ctl.en;
        assign mem_wdata[(LANES-1-k)*8 +: 8] =
            ctl.we ? store_data[DW-1-8*k -: 8] : 8'h00;
    end
endmodule

// File: rtl/lsu_wb.sv
module lsu_wb #(
    parameter int DW = lsu_pkg::LSU_DATA_W,
    parameter int TW = lsu_pkg::LSU_TAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_go,
    input  logic [TW-1:0] req_dest,
    input  logic [DW-1:0] mem_rdata,
    output logic          wb_valid,
    output logic [TW-1:0] wb_dest,
    output logic [DW-1:0] wb_data
);
    localparam int LANES = DW / 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_dest  <= '0;
        end else begin
            wb_valid <= load_go;
            wb_dest  <= load_go ? req_dest : wb_dest;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_gather
        assign wb_data[DW-1-8*k -: 8] =
            wb_valid ? mem_rdata[(LANES-1-k)*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/word_lsu.sv
module word_lsu
    import lsu_pkg::*;
#(
    parameter int AW = LSU_ADDR_W,
    parameter int DW = LSU_DATA_W,
    parameter int OW = LSU_OFF_W,
    parameter int TW = LSU_TAG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_store,
    input  logic [AW-1:0]   base,
    input  logic [OW-1:0]   offset,
    input  logic [DW-1:0]   store_data,
    input  logic [TW-1:0]   req_dest,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_en,
    output logic            mem_we,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            misalign_err,
    output logic            wb_valid,
    output logic [TW-1:0]   wb_dest,
    output logic [DW-1:0]   wb_data
);
    logic [AW-1:0] ea;
    logic          misaligned;
    logic          load_go;
    acc_kind_t     kind;

    assign kind = req_store ? ACC_STORE : ACC_LOAD;

    lsu_agu #(.AW(AW), .OW(OW), .LANES(DW/8)) u_agu (
        .base       (base),
        .offset     (offset),
        .ea         (ea),
        .misaligned (misaligned)
    );

    lsu_port #(.AW(AW), .DW(DW)) u_port (
        .req_valid    (req_valid),
        .kind         (kind),
        .ea           (ea),
        .misaligned   (misaligned),
        .store_data   (store_data),
        .mem_addr     (mem_addr),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .misalign_err (misalign_err),
        .load_go      (load_go)
    );

    lsu_wb #(.DW(DW), .TW(TW)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .load_go   (load_go),
        .req_dest  (req_dest),
        .mem_rdata (mem_rdata),
        .wb_valid  (wb_valid),
        .wb_dest   (wb_dest),
        .wb_data   (wb_data)
    );
endmodule

// File: rtl/word_lsu_chk.sv
module word_lsu_chk #(
    parameter int AW = lsu_pkg::LSU_ADDR_W,
    parameter int DW = lsu_pkg::LSU_DATA_W,
    parameter int OW = lsu_pkg::LSU_OFF_W,
    parameter int TW = lsu_pkg::LSU_TAG_W
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_store,
    input logic [AW-1:0]   base,
    input logic [OW-1:0]   offset,
    input logic [DW-1:0]   store_data,
    input logic [TW-1:0]   req_dest,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_en,
    input logic            mem_we,
    input logic [DW/8-1:0] mem_be,
    input logic [DW-1:0]   mem_wdata,
    input logic [DW-1:0]   mem_rdata,
    input logic            misalign_err,
    input logic            wb_valid,
    input logic [TW-1:0]   wb_dest,
    input logic [DW-1:0]   wb_data
);
    a_r1_addr_aligned_on_access: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_addr[1:0] == 2'b00));

    a_r3_err_blocks_access: assert property (@(posedge clk) disable iff (rst)
        misalign_err |-> (!mem_en && !mem_we && mem_be == '0));

    a_r3_err_no_writeback: assert property (@(posedge clk) disable iff (rst)
        misalign_err |=> !wb_valid);

    a_r4_store_full_enables: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_en && $countones(mem_be) == DW/8));

    a_r5_load_returns: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> (wb_valid && wb_dest == $past(req_dest)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!mem_en && !misalign_err && mem_be == '0));

    a_r9_store_no_writeback: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |=> !wb_valid);

    a_r2_err_needs_request: assert property (@(posedge clk) disable iff (rst)
        misalign_err |-> req_valid);
endmodule

bind word_lsu word_lsu_chk u_chk (.*);

// File: tb/word_lsu_tb.sv
`timescale 1ns/1ps
module word_lsu_tb;

    typedef struct packed {
        logic        st;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] data;
        logic [4:0]  dest;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0100, 16'h0004, 32'hA1B2_C3D4, 5'd0},
        '{1'b0, 32'h0000_0108, 16'hFFFC, 32'h0,         5'd7},
        '{1'b1, 32'hFFFF_FFFC, 16'h0008, 32'h0102_0304, 5'd0},
        '{1'b0, 32'h0000_0000, 16'h0004, 32'h0,         5'd31},
        '{1'b0, 32'h0000_0101, 16'h0000, 32'h0,         5'd3},
        '{1'b1, 32'h0000_0100, 16'h0002, 32'hDEAD_BEEF, 5'd0},
        '{1'b0, 32'h0000_7FFC, 16'h7FFF, 32'h0,         5'd9},
        '{1'b0, 32'h0001_0000, 16'h8000, 32'h0,         5'd12}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;
    logic [4:0]  req_dest = '0;
    logic [31:0] mem_addr;
    logic        mem_en;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        misalign_err;
    logic        wb_valid;
    logic [4:0]  wb_dest;
    logic [31:0] wb_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] mem_bytes [int unsigned];
    logic [7:0] shadow    [int unsigned];

    always #4 clk = ~clk;

    word_lsu u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .base(base), .offset(offset), .store_data(store_data), .req_dest(req_dest),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign_err(misalign_err),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data)
    );

    function automatic logic [7:0] mbyte(input int unsigned a);
        return mem_bytes.exists(a) ? mem_bytes[a] : 8'h00;
    endfunction

    function automatic logic [7:0] sbyte(input int unsigned a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    // Byte-addressed synchronous memory; byte at a+0 travels on bits [31:24].
    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            if (mem_be[3]) mem_bytes[mem_addr]      = mem_wdata[31:24];
            if (mem_be[2]) mem_bytes[mem_addr + 1]  = mem_wdata[23:16];
            if (mem_be[1]) mem_bytes[mem_addr + 2]  = mem_wdata[15:8];
            if (mem_be[0]) mem_bytes[mem_addr + 3]  = mem_wdata[7:0];
        end
        if (mem_en && !mem_we)
            mem_rdata <= {mbyte(mem_addr), mbyte(mem_addr + 1),
                          mbyte(mem_addr + 2), mbyte(mem_addr + 3)};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One request; combinational checks in the request cycle, writeback next cycle.
    task automatic issue(input vec_t v);
        logic [31:0] ea;
        logic        mis;
        logic [31:0] exp_rd;
        ea  = v.base + {{16{v.off[15]}}, v.off};
        mis = (ea[1:0] != 2'b00);
        exp_rd = {sbyte(ea), sbyte(ea + 1), sbyte(ea + 2), sbyte(ea + 3)};
        @(negedge clk);
        req_valid = 1'b1; req_store = v.st; base = v.base; offset = v.off;
        store_data = v.data; req_dest = v.dest;
        #1;
        chk(misalign_err == mis, "R2 misalign flag", {31'b0, misalign_err}, {31'b0, mis});
        if (mis) begin
            chk(!mem_en && !mem_we && mem_be == 4'b0000, "R3 no access when misaligned",
                {26'b0, mem_en, mem_we, mem_be}, 32'h0);
        end else begin
            chk(mem_addr == ea, "R1 effective address", mem_addr, ea);
            chk(mem_en && mem_be == 4'b1111, "R4 R5 full-word enables",
                {27'b0, mem_en, mem_be}, 32'h1F);
            chk(mem_we == v.st, "R4 R5 write enable", {31'b0, mem_we}, {31'b0, v.st});
            if (v.st) begin
                chk(mem_wdata == v.data, "R6 store lanes", mem_wdata, v.data);
                shadow[ea]     = v.data[31:24];
                shadow[ea + 1] = v.data[23:16];
                shadow[ea + 2] = v.data[15:8];
                shadow[ea + 3] = v.data[7:0];
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (mis) begin
            chk(!wb_valid, "R3 no writeback after misaligned", {31'b0, wb_valid}, 32'h0);
        end else if (v.st) begin
            chk(!wb_valid, "R9 no writeback after store", {31'b0, wb_valid}, 32'h0);
        end else begin
            chk(wb_valid && wb_dest == v.dest, "R5 writeback tag",
                {26'b0, wb_valid, wb_dest}, {26'b0, 1'b1, v.dest});
            chk(wb_data == exp_rd, "R6 load data", wb_data, exp_rd);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; failures++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!wb_valid && wb_data == 32'h0, "R7 reset state", {31'b0, wb_valid}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!wb_valid, "R7 after reset", {31'b0, wb_valid}, 32'h0);

        for (int i = 0; i < NV; i++) issue(VECS[i]);

        // R8: idle cycle with a misaligned address on the inputs stays quiet.
        @(negedge clk);
        req_valid = 1'b0; base = 32'h0000_0103; offset = 16'h0000; req_store = 1'b1;
        #1;
        chk(!mem_en && !mem_we && mem_be == 4'b0000 && !misalign_err, "R8 idle outputs",
            {26'b0, mem_en, mem_we, mem_be}, 32'h0);
        @(negedge clk);
        #1;
        chk(!wb_valid, "R8 idle no writeback", {31'b0, wb_valid}, 32'h0);

        // R6: bytes placed one by one must assemble most significant first.
        mem_bytes[32'h0000_0040] = 8'h11;
        mem_bytes[32'h0000_0041] = 8'h22;
        mem_bytes[32'h0000_0042] = 8'h33;
        mem_bytes[32'h0000_0043] = 8'h44;
        shadow[32'h0000_0040] = 8'h11;
        shadow[32'h0000_0041] = 8'h22;
        shadow[32'h0000_0042] = 8'h33;
        shadow[32'h0000_0043] = 8'h44;
        issue('{1'b0, 32'h0000_0040, 16'h0000, 32'h0, 5'd5});

        // R6: a store lands its top byte at the lowest address.
        issue('{1'b1, 32'h0000_0060, 16'h0000, 32'hAABB_CCDD, 5'd0});
        chk(mbyte(32'h60) == 8'hAA && mbyte(32'h63) == 8'hDD, "R6 store byte order",
            {mbyte(32'h60), mbyte(32'h61), mbyte(32'h62), mbyte(32'h63)}, 32'hAABBCCDD);

        // R1: negative offset crossing below zero wraps to the top of memory.
        issue('{1'b1, 32'h0000_0004, 16'hFFF8, 32'h5566_7788, 5'd0});
        issue('{1'b0, 32'hFFFF_FFF0, 16'h000C, 32'h0, 5'd17});

        // R2: each non-zero low-bit pattern is flagged.
        issue('{1'b0, 32'h0000_0200, 16'h0001, 32'h0, 5'd1});
        issue('{1'b1, 32'h0000_0200, 16'h0003, 32'h1234_5678, 5'd0});

        finish_run();
    end
endmodule